// File: doc/BRIEF.md
# Segmented Overlay RAM Address Mapper

This block sits between a 16-bit CPU and three possible responders: a 64K internal RAM on a fast 16-bit path, the console's own devices (system ROM, cartridge port, memory-mapped device page), and the external 8-bit expansion bus. For every memory cycle it looks at the top three address bits, which pick one of eight 8K segments. It then checks a seven-bit enable register. If the segment is enabled, the internal RAM answers. If it is not, the access is passed to whichever original device owns that window.

The enable register is reached only over the CPU's bit-serial I/O bus, starting at a parameterised bit address. Paging therefore uses no memory addresses. A disabled segment hides its RAM completely: reads go elsewhere, and a write never strobes the RAM, so writes aimed at the memory-mapped device page cannot leak into the RAM behind it. The block also tells the CPU how many wait states to insert. RAM cycles need none, pass-through cycles need a fixed number, and an optional extra wait applies to reads of the video read port.

Top module: `ovl_mapper`

## Requirements
- R1: After reset the enable register holds 1 in bit 0 (segment >2000) and bit 1 (segments >A000, >C000, >E000), and 0 in bits 2 to 6.
- R2: A bit-bus write with io_addr = BIT_BASE+k, for k from 0 to 6, loads io_wdata into enable bit k on the next clock. A write to any other bit address changes no enable bit.
- R3: While io_addr = BIT_BASE+k (k 0..6), io_hit is 1 and io_rdata shows enable bit k. Outside that range both are 0.
- R4: Segments are selected by cpu_addr[15:13]. The enable bit map is: bit 3 for segment 0, bit 0 for segment 1, bit 4 for segment 2, bit 5 for segment 3, bit 6 for segment 4, and bit 1 for segments 5 to 7. Bit 2 is the video-read wait enable.
- R5: During a memory cycle to an enabled segment, ram_cs is 1 and both con_sel and ext_sel are 0.
- R6: During a memory cycle to a disabled segment, ram_cs is 0 and ram_we is 0, for reads and writes alike. No write-through takes place.
- R7: A disabled segment 0, 3 or 4 raises con_sel. A disabled segment 1, 2, 5, 6 or 7 raises ext_sel.
- R8: ram_we is 1 only for a write cycle to an enabled segment.
- R9: Exactly one of ram_cs, con_sel and ext_sel is 1 while mem_en is 1, and none of them is 1 while mem_en is 0.
- R10: ram_addr equals cpu_addr, with no translation.
- R11: wait_req is high for exactly PASS_WAITS cycles at the start of each pass-through cycle, beginning in its first cycle. It stays low throughout an internal RAM cycle.
- R12: When the wait enable bit is set, a pass-through read in >8800 to >8BFF gets VDP_WAITS additional wait cycles. Writes there, and RAM-overlaid reads there, get none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| mem_en | input | 1 | Memory cycle active |
| mem_we | input | 1 | Memory cycle is a write |
| io_addr | input | IO_AW | Bit-serial I/O bus bit address |
| io_wr | input | 1 | Bit-bus write strobe |
| io_wdata | input | 1 | Bit-bus write value |
| io_rdata | output | 1 | Bit-bus read value |
| io_hit | output | 1 | Bit address falls in the enable register |
| ram_cs | output | 1 | Internal RAM select |
| ram_we | output | 1 | Internal RAM write strobe |
| ram_addr | output | 16 | Internal RAM address |
| con_sel | output | 1 | Pass to original console device |
| ext_sel | output | 1 | Pass to external expansion bus |
| vdp_wait_en | output | 1 | Video read wait enable bit state |
| wait_req | output | 1 | CPU wait-state request |

## Verification
The hardest situation to reach is a write aimed at a console-owned window whose RAM has just been hidden again. To get there, the bench first enables the overlay, writes through the RAM, and then clears the bit over the bit bus. It then issues a write to the same address and checks that the RAM strobe stays low while the console select rises. The video-port wait has a similar difficulty: it stacks on top of the pass-through wait only under a narrow combination of conditions. The bench therefore switches the wait bit and the device-page overlay in several combinations, and counts the wait cycles for reads and writes in each one.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int ADDR_W = 16;
  localparam int SEG_N  = 8;
  localparam int SEG_W  = 3;
  localparam int CTRL_N = 7;

  // enable register bit positions
  localparam int CB_LOW  = 0;
  localparam int CB_HIGH = 1;
  localparam int CB_WAIT = 2;
  localparam int CB_S0   = 3;
  localparam int CB_S2   = 4;
  localparam int CB_S3   = 5;
  localparam int CB_S4   = 6;

  typedef logic [CTRL_N-1:0] ctrl_t;
  typedef enum logic [1:0] {TGT_NONE, TGT_RAM, TGT_CON, TGT_EXT} tgt_e;

  localparam ctrl_t CTRL_RST = ctrl_t'((1 << CB_LOW) | (1 << CB_HIGH));

  function automatic logic [SEG_W-1:0] seg_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SEG_W];
  endfunction

  function automatic logic seg_enable(input ctrl_t c, input logic [SEG_W-1:0] s);
    case (s)
      3'd0:    return c[CB_S0];
      3'd1:    return c[CB_LOW];
      3'd2:    return c[CB_S2];
      3'd3:    return c[CB_S3];
      3'd4:    return c[CB_S4];
      default: return c[CB_HIGH];
    endcase
  endfunction

  function automatic logic seg_console(input logic [SEG_W-1:0] s);
    return (s == 3'd0) || (s == 3'd3) || (s == 3'd4);
  endfunction

  function automatic logic vdp_read_port(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:10] == 6'b100010;
  endfunction

  function automatic int wait_load(input tgt_e t, input logic vdp_rd,
                                   input logic wen, input int pass_w,
                                   input int vdp_w);
    int n;
    n = 0;
    if (t == TGT_CON || t == TGT_EXT) begin
      n = pass_w;
      if (vdp_rd && wen) n = n + vdp_w;
    end
    return n;
  endfunction
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
  import ovl_pkg::*;
#(
  parameter int IO_AW    = 12,
  parameter int BIT_BASE = 12'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_wdata,
  output ctrl_t            ctrl,
  output logic             io_rdata,
  output logic             io_hit
);
  logic [IO_AW-1:0] off;
  logic [CTRL_N-1:0] bit_sel;

  assign off = io_addr - IO_AW'(BIT_BASE);

  genvar k;
  generate
    for (k = 0; k < CTRL_N; k++) begin : g_bit
      assign bit_sel[k] = (io_addr >= IO_AW'(BIT_BASE)) && (off == IO_AW'(k));
      always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl[k] <= CTRL_RST[k];
        else if (io_wr && bit_sel[k]) ctrl[k] <= io_wdata;
      end
    end
  endgenerate

  assign io_hit   = |bit_sel;
  assign io_rdata = |(bit_sel & ctrl);
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
(
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_en,
  input  logic              mem_we,
  input  ctrl_t             ctrl,
  output tgt_e              tgt,
  output logic              ram_cs,
  output logic              ram_we,
  output logic              con_sel,
  output logic              ext_sel,
  output logic              vdp_rd,
  output logic [ADDR_W-1:0] ram_addr
);
  logic [SEG_N-1:0] seg_on;
  logic [SEG_N-1:0] seg_hit;
  logic [SEG_W-1:0] seg;

  assign seg = seg_of(cpu_addr);

  genvar s;
  generate
    for (s = 0; s < SEG_N; s++) begin : g_seg
      assign seg_on[s]  = seg_enable(ctrl, SEG_W'(s));
      assign seg_hit[s] = (seg == SEG_W'(s));
    end
  endgenerate

  always_comb begin
    if (!mem_en)                   tgt = TGT_NONE;
    else if (|(seg_on & seg_hit))  tgt = TGT_RAM;
    else if (seg_console(seg))     tgt = TGT_CON;
    else                           tgt = TGT_EXT;
  end

  assign ram_cs   = (tgt == TGT_RAM);
  assign ram_we   = ram_cs && mem_we;
  assign con_sel  = (tgt == TGT_CON);
  assign ext_sel  = (tgt == TGT_EXT);
  assign vdp_rd   = !mem_we && vdp_read_port(cpu_addr);
  assign ram_addr = cpu_addr;
endmodule

// File: rtl/ovl_wait_gen.sv
module ovl_wait_gen
  import ovl_pkg::*;
#(
  parameter int PASS_WAITS = 4,
  parameter int VDP_WAITS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_en,
  input  tgt_e tgt,
  input  logic vdp_rd,
  input  logic wait_en,
  output logic cyc_start,
  output logic wait_req
);
  localparam int CNT_W = $clog2(PASS_WAITS + VDP_WAITS + 1) + 1;

  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load;

  assign cyc_start = mem_en && !en_q;
  assign load      = CNT_W'(wait_load(tgt, vdp_rd, wait_en, PASS_WAITS, VDP_WAITS));
  assign wait_req  = mem_en && (cyc_start ? (load != '0) : (cnt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= mem_en;
      if (!mem_en)            cnt <= '0;
      else if (cyc_start)     cnt <= (load == '0) ? '0 : load - 1'b1;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ovl_mapper.sv
module ovl_mapper
  import ovl_pkg::*;
#(
  parameter int IO_AW      = 12,
  parameter int BIT_BASE   = 12'h200,
  parameter int PASS_WAITS = 4,
  parameter int VDP_WAITS  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpu_addr,
  input  logic             mem_en,
  input  logic             mem_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_wdata,
  output logic             io_rdata,
  output logic             io_hit,
  output logic             ram_cs,
  output logic             ram_we,
  output logic [15:0]      ram_addr,
  output logic             con_sel,
  output logic             ext_sel,
  output logic             vdp_wait_en,
  output logic             wait_req
);
  ctrl_t ctrl;
  tgt_e  tgt;
  logic  vdp_rd;
  logic  cyc_start;

  ovl_ctrl_reg #(.IO_AW(IO_AW), .BIT_BASE(BIT_BASE)) u_reg (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .ctrl(ctrl), .io_rdata(io_rdata), .io_hit(io_hit)
  );

  ovl_decode u_dec (
    .cpu_addr(cpu_addr), .mem_en(mem_en), .mem_we(mem_we), .ctrl(ctrl),
    .tgt(tgt), .ram_cs(ram_cs), .ram_we(ram_we), .con_sel(con_sel),
    .ext_sel(ext_sel), .vdp_rd(vdp_rd), .ram_addr(ram_addr)
  );

  ovl_wait_gen #(.PASS_WAITS(PASS_WAITS), .VDP_WAITS(VDP_WAITS)) u_wait (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .tgt(tgt), .vdp_rd(vdp_rd),
    .wait_en(ctrl[CB_WAIT]), .cyc_start(cyc_start), .wait_req(wait_req)
  );

  assign vdp_wait_en = ctrl[CB_WAIT];
endmodule

// File: rtl/ovl_mapper_chk.sv
module ovl_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_en,
  input logic        mem_we,
  input logic        io_wr,
  input logic        ram_cs,
  input logic        ram_we,
  input logic        con_sel,
  input logic        ext_sel,
  input logic        vdp_wait_en,
  input logic        wait_req,
  input logic [15:0] cpu_addr,
  input logic [15:0] ram_addr
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $countones({ram_cs, con_sel, ext_sel}) == 1); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> !(ram_cs || con_sel || ext_sel || wait_req)); // R9
  AST_NO_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs); // R6
  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (mem_en && mem_we)); // R8
  AST_RAM_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_en) && ram_cs) |-> !wait_req); // R11
  AST_PASS_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_en) && !ram_cs) |-> wait_req); // R11
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(vdp_wait_en)); // R2
  AST_ADDR_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> ram_addr == cpu_addr); // R10
endmodule

bind ovl_mapper ovl_mapper_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we), .io_wr(io_wr),
  .ram_cs(ram_cs), .ram_we(ram_we), .con_sel(con_sel), .ext_sel(ext_sel),
  .vdp_wait_en(vdp_wait_en), .wait_req(wait_req), .cpu_addr(cpu_addr),
  .ram_addr(ram_addr)
);

// File: tb/ovl_mapper_tb.sv
module ovl_mapper_tb_top;
  localparam int IO_AW = 12;
  localparam int BASE  = 12'h200;
  localparam int PASSW = 4;
  localparam int VDPW  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic mem_en = 1'b0, mem_we = 1'b0;
  logic [IO_AW-1:0] io_addr = '0;
  logic io_wr = 1'b0, io_wdata = 1'b0;
  logic io_rdata, io_hit, ram_cs, ram_we, con_sel, ext_sel, vdp_wait_en, wait_req;
  logic [15:0] ram_addr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [6:0] model;

  typedef struct {
    logic [15:0] addr;
    logic cs, we, con, ext;
    int   waits;
    string tag;
  } item_t;
  item_t exp_q[$];
  item_t obs_q[$];

  always #10 clk = ~clk;

  ovl_mapper #(.IO_AW(IO_AW), .BIT_BASE(BASE), .PASS_WAITS(PASSW), .VDP_WAITS(VDPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_en(mem_en), .mem_we(mem_we),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_hit(io_hit), .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
    .con_sel(con_sel), .ext_sel(ext_sel), .vdp_wait_en(vdp_wait_en), .wait_req(wait_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // bench-side view of which bit guards each segment
  function automatic logic bench_on(input logic [15:0] a);
    case (a >> 13)
      0: return model[3];
      1: return model[0];
      2: return model[4];
      3: return model[5];
      4: return model[6];
      default: return model[1];
    endcase
  endfunction

  task automatic bit_wr(input int k, input logic v);
    @(negedge clk);
    io_addr = IO_AW'(BASE + k); io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (k >= 0 && k < 7) model[k] = v;
  endtask

  task automatic bit_rd(input int k, output logic v, output logic h);
    @(negedge clk);
    io_addr = IO_AW'(BASE + k);
    #1; v = io_rdata; h = io_hit;
  endtask

  // driver: pushes expectation, runs the cycle, records observation
  task automatic access(input logic [15:0] a, input logic w, input string tag);
    item_t e, o;
    int sa = int'(a >> 13);
    logic on = bench_on(a);
    logic con_seg = (sa == 0 || sa == 3 || sa == 4);
    e.addr = a; e.tag = tag;
    e.cs = on; e.we = on && w;
    e.con = !on && con_seg; e.ext = !on && !con_seg;
    e.waits = on ? 0 : PASSW + ((!w && a[15:10] == 6'b100010 && model[2]) ? VDPW : 0);
    exp_q.push_back(e);
    @(negedge clk);
    cpu_addr = a; mem_we = w; mem_en = 1'b1;
    #1;
    o.addr = ram_addr; o.cs = ram_cs; o.we = ram_we; o.con = con_sel; o.ext = ext_sel;
    o.tag = tag;
    o.waits = wait_req ? 1 : 0;
    for (int i = 0; i < PASSW + VDPW + 2; i++) begin
      @(negedge clk); #1;
      if (wait_req) o.waits++;
    end
    @(negedge clk);
    mem_en = 1'b0; mem_we = 1'b0;
    #1;
    check({tag, " R9 idle"}, {ram_cs, con_sel, ext_sel}, 3'b000);
    obs_q.push_back(o);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      item_t e, o;
      wait (obs_q.size() > 0);
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      check({e.tag, " R10 addr"}, o.addr, e.addr);
      check({e.tag, " R5 ram_cs"}, o.cs, e.cs);
      check({e.tag, " R8 R6 ram_we"}, o.we, e.we);
      check({e.tag, " R7 con_sel"}, o.con, e.con);
      check({e.tag, " R7 ext_sel"}, o.ext, e.ext);
      check({e.tag, " R11 R12 waits"}, o.waits, e.waits);
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic v, h;
    model = 7'b0000011;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R3 reset contents over the bit bus
    for (int k = 0; k < 7; k++) begin
      bit_rd(k, v, h);
      check($sformatf("R1 reset bit %0d", k), v, model[k]);
      check($sformatf("R3 hit bit %0d", k), h, 1'b1);
    end
    bit_rd(7, v, h);
    check("R3 out of range hit", {h, v}, 2'b00);
    bit_rd(-1, v, h);
    check("R3 below range hit", {h, v}, 2'b00);
    // R4 reset map over all segments, reads and writes
    for (int s = 0; s < 8; s++) begin
      access(16'(s * 16'h2000 + 16'h0123), 1'b0, $sformatf("R4 rd seg%0d", s));
      access(16'(s * 16'h2000 + 16'h1FFE), 1'b1, $sformatf("R4 wr seg%0d", s));
    end
    // R2 out-of-range writes ignored
    bit_wr(7, 1'b1);
    bit_wr(-1, 1'b1);
    for (int k = 0; k < 7; k++) begin
      bit_rd(k, v, h);
      check($sformatf("R2 ignore bit %0d", k), v, model[k]);
    end
    // overlay ROM, device page, cartridge and peripheral windows
    bit_wr(3, 1'b1); bit_wr(6, 1'b1); bit_wr(5, 1'b1); bit_wr(4, 1'b1);
    for (int k = 0; k < 7; k++) begin
      bit_rd(k, v, h);
      check($sformatf("R2 set bit %0d", k), v, model[k]);
    end
    access(16'h0040, 1'b1, "R5 wr rom overlay");
    access(16'h8300, 1'b1, "R5 wr scratch overlay");
    access(16'h8800, 1'b0, "R12 vdp read overlaid");
    access(16'h6000, 1'b0, "R5 rd cartridge overlay");
    access(16'h4000, 1'b0, "R5 rd peripheral overlay");
    // hide device page again: writes must not reach RAM
    bit_wr(6, 1'b0);
    access(16'h8C00, 1'b1, "R6 wr device page hidden");
    access(16'h8300, 1'b1, "R6 wr scratch hidden");
    // R12 video read wait
    access(16'h8800, 1'b0, "R12 vdp rd wait off");
    bit_wr(2, 1'b1);
    bit_rd(2, v, h);
    check("R2 wait enable pin", vdp_wait_en, 1'b1);
    access(16'h8800, 1'b0, "R12 vdp rd wait on");
    access(16'h8BFE, 1'b0, "R12 vdp rd top wait on");
    access(16'h8C00, 1'b0, "R12 outside vdp port");
    access(16'h8800, 1'b1, "R12 vdp wr no extra");
    // R4 high area bit covers three segments
    bit_wr(1, 1'b0);
    access(16'hA000, 1'b0, "R4 high seg5 off");
    access(16'hC000, 1'b1, "R6 high seg6 off wr");
    access(16'hFFFE, 1'b0, "R4 high seg7 off");
    bit_wr(0, 1'b0);
    access(16'h2000, 1'b1, "R7 low exp off wr");
    bit_wr(1, 1'b1);
    access(16'hE000, 1'b1, "R8 high seg7 on wr");
    // R1 reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model = 7'b0000011;
    for (int k = 0; k < 7; k++) begin
      bit_rd(k, v, h);
      check($sformatf("R1 rereset bit %0d", k), v, model[k]);
    end
    access(16'h0000, 1'b1, "R1 rom after reset");
    wait (obs_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule